// File: doc/BRIEF.md
# PWM Fault Action Controller

An up-counting PWM timer with two compare channels, each guarded by one recoverable fault input. Fault A acts on channel 0 and fault B on channel 1. For each fault, software picks any mix of four actions. The output clamp forces the channel low. The cycle restart aborts the running period. The hardware halt freezes the counter while the fault lasts. The software halt freezes the counter until the fault is gone and the fault's sticky status bit has been cleared.

The counter runs from zero up to a programmable period value and then wraps, which starts a new cycle. In dual-ramp mode a cycle index flips at every new cycle. Fault A is only honoured while the index is 0, and fault B only while it is 1. The fault inputs are taken as already filtered and synchronous levels. Every output is registered, so the waveform, count, index and status all move together one clock after the inputs that caused them.

Top module: `pwm_fault_ctrl`

## Requirements
- R1: While reset is asserted, count_o, cyc_idx_o, pwm_o and fault_stat_o are all zero.
- R2: With no honoured fault, count_o steps by one each clock from 0 up to top_i and then returns to 0, which starts a new cycle. pwm_o[n] is 1 exactly when count_o is below that channel's compare value.
- R3: Clamp enable for fault n (keep_en_i[n], bit 0 = fault A) together with an honoured fault n forces pwm_o[n] to 0 on the next clock.
- R4: Once an output clamp has been set, it stays set until the first new cycle that starts while the fault is no longer honoured. The output is released in that cycle.
- R5: Restart enable (restart_en_i[n]) together with an honoured fault n, and no active halt, sets count_o to 0 on the next clock and starts a new cycle.
- R6: In single-ramp mode (dual_ramp_i = 0), pwm_o[n] stays 0 for as long as a restarting fault n is honoured.
- R7: A halt code of 1 (halt_mode_i[1:0] for A, [3:2] for B) is hardware halt. While the fault is honoured, count_o and cyc_idx_o hold and pwm_o[n] is 0. Counting resumes on the clock after the fault drops.
- R8: When hardware halt and restart are both enabled for a fault, the first advance after the fault clears sets the count to 0 and starts a new cycle.
- R9: A halt code of 2 is software halt. An honoured fault freezes the counter and clamps its channel. Both stay in force until the fault is absent and fault_stat_o[n] has been cleared.
- R10: Halt codes 0 and 3 never stop the counter.
- R11: In dual-ramp mode cyc_idx_o toggles at every new cycle. In single-ramp mode it stays 0.
- R12: In dual-ramp mode, fault A is ignored while cyc_idx_o = 1 and fault B is ignored while cyc_idx_o = 0. An ignored fault sets no status bit and takes no action.
- R13: fault_stat_o[n] is set by an honoured fault n. It is cleared by a stat_clr_i[n] strobe only when fault n is not honoured in that same cycle.
- R14: Any combination of actions, modes and fault patterns follows R2 to R13 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_ramp_i | input | 1 | 1 = dual-ramp mode with alternating cycle index |
| top_i | input | CNT_W | Last count value of a cycle |
| cmp0_i | input | CNT_W | Compare value of channel 0 |
| cmp1_i | input | CNT_W | Compare value of channel 1 |
| fault_a_i | input | 1 | Fault A level, acts on channel 0 |
| fault_b_i | input | 1 | Fault B level, acts on channel 1 |
| keep_en_i | input | 2 | Output clamp enable per fault (bit 0 = A) |
| restart_en_i | input | 2 | Cycle restart enable per fault |
| halt_mode_i | input | 4 | Halt code, [1:0] fault A, [3:2] fault B |
| stat_clr_i | input | 2 | Status clear strobe per fault |
| pwm_o | output | 2 | Channel waveforms (bit 0 = channel 0) |
| count_o | output | CNT_W | Counter value |
| cyc_idx_o | output | 1 | Cycle index (0 = cycle A) |
| fault_stat_o | output | 2 | Sticky fault status per fault |

## Verification
The bench concentrates on four corner cases. The first is a clamp whose fault drops in the middle of a cycle. A design that released it at once, rather than at the next cycle start, would show a stray high pulse. The second is a status-clear strobe issued while the fault is still present. A design that honoured it would leave the software halt early or lose the status bit. The third is halt combined with restart. A wrong design would resume from the frozen count instead of from zero. The fourth is dual-ramp gating. A design that ignored the cycle index would let fault A clamp or halt during cycle B. Long random runs mix every action code, including the reserved halt code, and catch interactions such as a pending restart that outlives its halt.

// File: rtl/pwm_fault_pkg.sv
`timescale 1ns/1ps
package pwm_fault_pkg;

    typedef enum logic [1:0] {
        HALT_OFF = 2'd0,
        HALT_HW  = 2'd1,
        HALT_SW  = 2'd2,
        HALT_RSV = 2'd3
    } halt_e;

    // Per-fault decoded action requests for the current cycle
    typedef struct packed {
        logic honoured;
        logic hw_hold;
        logic sw_req;
        logic rst_req;
        logic keep_req;
    } fault_req_t;

endpackage

// File: rtl/pwm_fault_gate.sv
`timescale 1ns/1ps
module pwm_fault_gate
    import pwm_fault_pkg::*;
#(
    parameter int unsigned IDX = 0
) (
    input  logic       fault_i,
    input  logic       dual_i,
    input  logic       cyc_idx_i,
    input  logic       keep_en_i,
    input  logic       restart_en_i,
    input  logic [1:0] halt_mode_i,
    output fault_req_t req_o
);
    localparam logic OWN_IDX = IDX[0];

    halt_e mode;
    logic  honoured;

    always_comb begin
        mode     = halt_e'(halt_mode_i);
        // In dual-ramp mode a fault only counts in its own cycle
        honoured = fault_i && (!dual_i || (cyc_idx_i == OWN_IDX));

        req_o          = '0;
        req_o.honoured = honoured;
        req_o.hw_hold  = honoured && (mode == HALT_HW);
        req_o.sw_req   = honoured && (mode == HALT_SW);
        req_o.rst_req  = honoured && restart_en_i;
        req_o.keep_req = honoured && keep_en_i;
    end
endmodule

// File: rtl/pwm_fault_cnt.sv
`timescale 1ns/1ps
module pwm_fault_cnt #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_CH  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dual_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             freeze_i,
    input  logic [N_CH-1:0]  rst_req_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] count_nxt_o,
    output logic             idx_o,
    output logic             new_cyc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             idx;
        logic [N_CH-1:0]  pend;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       wrap;
    logic       new_cyc;

    always_comb begin
        s_d     = s_q;
        wrap    = (s_q.count >= top_i);
        new_cyc = !freeze_i && ((|rst_req_i) || (|s_q.pend) || wrap);

        if (freeze_i) begin
            s_d.count = s_q.count;
            // a restart requested during a halt waits for the release
            s_d.pend  = s_q.pend | rst_req_i;
        end else begin
            s_d.count = new_cyc ? '0 : s_q.count + 1'b1;
            s_d.pend  = '0;
        end

        s_d.idx = dual_i ? (s_q.idx ^ new_cyc) : 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o     = s_q.count;
    assign count_nxt_o = s_d.count;
    assign idx_o       = s_q.idx;
    assign new_cyc_o   = new_cyc;
endmodule

// File: rtl/pwm_fault_chan.sv
`timescale 1ns/1ps
module pwm_fault_chan
    import pwm_fault_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dual_i,
    input  fault_req_t       req_i,
    input  logic             clr_i,
    input  logic             new_cyc_i,
    input  logic [CNT_W-1:0] count_nxt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             hold_o,
    output logic             pwm_o,
    output logic             stat_o
);
    typedef struct packed {
        logic kc;    // output clamp latched until a clean cycle start
        logic swh;   // software halt still pending
        logic stat;  // sticky fault status
        logic pwm;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic        clamp;

    assign hold_o = req_i.hw_hold || req_i.sw_req || s_q.swh;

    always_comb begin
        s_d      = s_q;
        s_d.stat = req_i.honoured || (s_q.stat && !clr_i);
        s_d.swh  = req_i.sw_req || (s_q.swh && s_d.stat);
        s_d.kc   = req_i.keep_req || (s_q.kc && !new_cyc_i);
        clamp    = s_d.kc || hold_o || (!dual_i && req_i.rst_req);
        s_d.pwm  = (count_nxt_i < cmp_i) && !clamp;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o  = s_q.pwm;
    assign stat_o = s_q.stat;
endmodule

// File: rtl/pwm_fault_ctrl.sv
`timescale 1ns/1ps
module pwm_fault_ctrl
    import pwm_fault_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dual_ramp_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] cmp0_i,
    input  logic [CNT_W-1:0] cmp1_i,
    input  logic             fault_a_i,
    input  logic             fault_b_i,
    input  logic [1:0]       keep_en_i,
    input  logic [1:0]       restart_en_i,
    input  logic [3:0]       halt_mode_i,
    input  logic [1:0]       stat_clr_i,
    output logic [1:0]       pwm_o,
    output logic [CNT_W-1:0] count_o,
    output logic             cyc_idx_o,
    output logic [1:0]       fault_stat_o
);
    localparam int unsigned N_CH = 2;

    logic [N_CH-1:0][CNT_W-1:0] cmp;
    logic [N_CH-1:0]            fault;
    fault_req_t [N_CH-1:0]      req;
    logic [N_CH-1:0]            rst_req;
    logic [N_CH-1:0]            hold;
    logic [CNT_W-1:0]           count_nxt;
    logic                       new_cyc;
    logic                       idx;

    assign cmp[0]   = cmp0_i;
    assign cmp[1]   = cmp1_i;
    assign fault[0] = fault_a_i;
    assign fault[1] = fault_b_i;

    pwm_fault_cnt #(
        .CNT_W (CNT_W),
        .N_CH  (N_CH)
    ) cnt_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .dual_i      (dual_ramp_i),
        .top_i       (top_i),
        .freeze_i    (|hold),
        .rst_req_i   (rst_req),
        .count_o     (count_o),
        .count_nxt_o (count_nxt),
        .idx_o       (idx),
        .new_cyc_o   (new_cyc)
    );

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        pwm_fault_gate #(
            .IDX (n)
        ) gate_i (
            .fault_i      (fault[n]),
            .dual_i       (dual_ramp_i),
            .cyc_idx_i    (idx),
            .keep_en_i    (keep_en_i[n]),
            .restart_en_i (restart_en_i[n]),
            .halt_mode_i  (halt_mode_i[2*n +: 2]),
            .req_o        (req[n])
        );

        assign rst_req[n] = req[n].rst_req;

        pwm_fault_chan #(
            .CNT_W (CNT_W)
        ) chan_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .dual_i      (dual_ramp_i),
            .req_i       (req[n]),
            .clr_i       (stat_clr_i[n]),
            .new_cyc_i   (new_cyc),
            .count_nxt_i (count_nxt),
            .cmp_i       (cmp[n]),
            .hold_o      (hold[n]),
            .pwm_o       (pwm_o[n]),
            .stat_o      (fault_stat_o[n])
        );
    end

    assign cyc_idx_o = idx;
endmodule

// File: rtl/pwm_fault_ctrl_chk.sv
`timescale 1ns/1ps
module pwm_fault_ctrl_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             dual_ramp_i,
    input logic             fault_a_i,
    input logic             fault_b_i,
    input logic [1:0]       keep_en_i,
    input logic             restart_a_i,
    input logic [3:0]       halt_mode_i,
    input logic             clr_b_i,
    input logic [1:0]       pwm_o,
    input logic [CNT_W-1:0] count_o,
    input logic             cyc_idx_o,
    input logic [1:0]       fault_stat_o
);
    logic hon_a, hon_b, no_halt;

    assign hon_a   = fault_a_i && (!dual_ramp_i || !cyc_idx_o);
    assign hon_b   = fault_b_i && (!dual_ramp_i ||  cyc_idx_o);
    assign no_halt = (halt_mode_i[1:0] == 2'd0 || halt_mode_i[1:0] == 2'd3)
                  && (halt_mode_i[3:2] == 2'd0 || halt_mode_i[3:2] == 2'd3)
                  && (fault_stat_o == 2'b00);

    assert_keep_clamp_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (keep_en_i[0] && hon_a) |=> !pwm_o[0]);

    assert_keep_clamp_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (keep_en_i[1] && hon_b) |=> !pwm_o[1]);

    assert_restart_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restart_a_i && hon_a && no_halt) |=> (count_o == '0));

    assert_hw_halt_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_mode_i[1:0] == 2'd1 && hon_a) |=> $stable(count_o));

    assert_sw_halt_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_mode_i[3:2] == 2'd2 && hon_b) |=> $stable(count_o));

    assert_single_idx_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dual_ramp_i |=> !cyc_idx_o);

    assert_status_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_stat_o[1] && !clr_b_i) |=> fault_stat_o[1]);
endmodule

bind pwm_fault_ctrl pwm_fault_ctrl_chk #(
    .CNT_W (CNT_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dual_ramp_i  (dual_ramp_i),
    .fault_a_i    (fault_a_i),
    .fault_b_i    (fault_b_i),
    .keep_en_i    (keep_en_i),
    .restart_a_i  (restart_en_i[0]),
    .halt_mode_i  (halt_mode_i),
    .clr_b_i      (stat_clr_i[1]),
    .pwm_o        (pwm_o),
    .count_o      (count_o),
    .cyc_idx_o    (cyc_idx_o),
    .fault_stat_o (fault_stat_o)
);

// File: tb/pwm_fault_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_fault_ctrl_tb_top;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             dual;
    logic [CNT_W-1:0] top, cmp0, cmp1;
    logic             fa, fb;
    logic [1:0]       keep_en, rst_en, clr;
    logic [3:0]       halt;
    logic [1:0]       pwm, stat;
    logic [CNT_W-1:0] cnt;
    logic             idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    logic [CNT_W-1:0] m_cnt;
    logic             m_idx;
    logic [1:0]       m_pend, m_kc, m_swh, m_stat, m_pwm;

    pwm_fault_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .dual_ramp_i  (dual),
        .top_i        (top),
        .cmp0_i       (cmp0),
        .cmp1_i       (cmp1),
        .fault_a_i    (fa),
        .fault_b_i    (fb),
        .keep_en_i    (keep_en),
        .restart_en_i (rst_en),
        .halt_mode_i  (halt),
        .stat_clr_i   (clr),
        .pwm_o        (pwm),
        .count_o      (cnt),
        .cyc_idx_o    (idx),
        .fault_stat_o (stat)
    );

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    // expected next state from the requirements
    task automatic model_step();
        logic [1:0] hon, hwh, swr, rrq, swa, hld, nstat;
        logic [1:0] f;
        logic [1:0] cm;
        logic       frz, nc;
        logic [CNT_W-1:0] nxt;
        if (!rst_n) begin
            m_cnt = '0; m_idx = 0; m_pend = 0; m_kc = 0; m_swh = 0; m_stat = 0; m_pwm = 0;
            return;
        end
        f = {fb, fa};
        for (int n = 0; n < 2; n++) begin
            hon[n] = f[n] && (!dual || (m_idx == n[0]));                // R12
            hwh[n] = hon[n] && (halt[2*n +: 2] == 2'd1);                // R7
            swr[n] = hon[n] && (halt[2*n +: 2] == 2'd2);                // R9
            rrq[n] = hon[n] && rst_en[n];                               // R5
            swa[n] = m_swh[n] || swr[n];
            hld[n] = hwh[n] || swa[n];
        end
        frz = |hld;
        nc  = !frz && ((|rrq) || (|m_pend) || (m_cnt >= top));          // R2 R8
        nxt = frz ? m_cnt : (nc ? '0 : m_cnt + 1'b1);
        for (int n = 0; n < 2; n++) begin
            m_pend[n] = (rrq[n] && frz) || (m_pend[n] && !nc);
            nstat[n]  = hon[n] || (m_stat[n] && !clr[n]);               // R13
            m_swh[n]  = swr[n] || (m_swh[n] && nstat[n]);
            m_kc[n]   = (keep_en[n] && hon[n]) || (m_kc[n] && !nc);     // R3 R4
        end
        m_stat = nstat;
        cm = {cmp1 > nxt, cmp0 > nxt};
        for (int n = 0; n < 2; n++)
            m_pwm[n] = cm[n] && !(m_kc[n] || hld[n] || (!dual && rrq[n])); // R6
        m_idx = dual ? (m_idx ^ nc) : 1'b0;                             // R11
        m_cnt = nxt;
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, "count", 32'(cnt), 32'(m_cnt));
        check(tag, "cyc_idx", 32'(idx), 32'(m_idx));
        check(tag, "pwm0", 32'(pwm[0]), 32'(m_pwm[0]));
        check(tag, "pwm1", 32'(pwm[1]), 32'(m_pwm[1]));
        check(tag, "status", 32'(stat), 32'(m_stat));
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        dual = 0; top = 8'd9; cmp0 = 8'd4; cmp1 = 8'd11;
        fa = 0; fb = 0; keep_en = 0; rst_en = 0; halt = 0; clr = 0;
        run("R1", 3);
        rst_n = 1'b1;

        // plain counting, two periods
        run("R2", 25);
        top = 8'd5; run("R2", 14);
        top = 8'd9; run("R11", 4);

        // output clamp with mid-cycle release
        keep_en = 2'b01; run("R2", 3);
        fa = 1; run("R3", 3);
        fa = 0; run("R4", 14);
        keep_en = 2'b10; cmp1 = 8'd6; run("R2", 2);
        fb = 1; run("R3", 2);
        fb = 0; run("R4", 12);
        keep_en = 0; clr = 2'b11; run("R13", 1); clr = 0;

        // restart in single ramp
        rst_en = 2'b01; run("R2", 4);
        fa = 1; run("R5", 1); run("R6", 4);
        fa = 0; run("R5", 12);

        // hardware halt
        rst_en = 0; halt = 4'b0001; run("R2", 3);
        fa = 1; run("R7", 5);
        fa = 0; run("R7", 10);

        // hardware halt with restart
        rst_en = 2'b01; run("R2", 3);
        fa = 1; run("R8", 4);
        fa = 0; run("R8", 12);
        clr = 2'b01; run("R13", 1); clr = 0;

        // software halt and acknowledge ordering
        rst_en = 0; halt = 4'b0010; run("R2", 3);
        fa = 1; run("R9", 3);
        clr = 2'b01; run("R13", 2); clr = 0;
        fa = 0; run("R9", 4);
        clr = 2'b01; run("R9", 1); clr = 0;
        run("R9", 10);

        // reserved and off codes
        halt = 4'b1111; fa = 1; fb = 1; run("R10", 14);
        halt = 4'b0000; run("R10", 6);
        fa = 0; fb = 0; clr = 2'b11; run("R13", 2); clr = 0;

        // dual ramp gating
        dual = 1; top = 8'd7; cmp0 = 8'd6; cmp1 = 8'd6; keep_en = 2'b11;
        run("R11", 20);
        fa = 1; run("R12", 20); fa = 0; run("R11", 18);
        fb = 1; run("R12", 20); fb = 0; run("R11", 18);
        keep_en = 0; rst_en = 2'b01; fa = 1; run("R12", 10); fa = 0;
        rst_en = 0; halt = 4'b0100; fb = 1; run("R12", 20); fb = 0;
        halt = 0; clr = 2'b11; run("R13", 2); clr = 0;

        // random mixture
        void'($urandom(32'h5eed_0042));
        for (int blk = 0; blk < 40; blk++) begin
            dual    = 1'($urandom % 2);
            keep_en = 2'($urandom);
            rst_en  = 2'($urandom);
            halt    = 4'($urandom);
            top     = CNT_W'(3 + $urandom % 12);
            cmp0    = CNT_W'($urandom % (top + 3));
            cmp1    = CNT_W'($urandom % (top + 3));
            for (int i = 0; i < 100; i++) begin
                if ($urandom % 6 == 0) fa = ~fa;
                if ($urandom % 6 == 0) fb = ~fb;
                clr = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
                tick("R14");
            end
        end

        done = 1;
        finish_run();
    end
endmodule